// File: doc/BRIEF.md
# Parallel Flash Program/Erase Sequencer

This block sits on the host side of a byte-wide parallel flash bus. A client hands it one operation through a valid/ready request port: a byte program, a sector erase, a whole-array erase or a read of one identification byte. The block then produces the unlock write cycles that the flash demands before any change, with chip-enable, write-enable and output-enable strobes whose widths are set in clock counts by parameters. A single bus-cycle engine produces every write and read. The top-level sequencer walks a computed command table and drives that engine.

Once the last command write has gone out, the block polls the target location to detect completion. While the flash is working internally, bit 6 of every read flips. Completion is accepted only when a run of successive reads all agree in bit 6. This guards against a finish that lands between two reads. A saturating cycle counter ends a poll that never settles and flags an error. An identification read enters the ID mode, waits, reads one byte, leaves the ID mode and waits again before it reports the byte.

Top module: `pfs_flash_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are 1, and `done` and `err` are 0.
- R2: Op code 0 (program) issues exactly four writes, in this order: A_h AAh at 555h, 55h at 2AAh, A0h at 555h, then `req_data` at `req_addr`.
- R3: Op code 1 (sector erase) issues exactly six writes: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 20h at `req_addr`. The flash clears the 128-byte sector that contains that address.
- R4: Op code 2 (full erase) issues the same first five writes as R3, then 10h at 555h.
- R5: `fl_we_n` stays low for exactly `WE_LOW_CYC` cycles per write and high for at least `WE_HIGH_CYC` cycles between writes. Address and write data stay stable while it is low. `fl_we_n` is low only while `fl_ce_n` is low and `fl_oe_n` is high.
- R6: Each read holds `fl_ce_n` and `fl_oe_n` low for exactly `RD_CYC` cycles, with the bus not driven. The byte is sampled on the last of those cycles.
- R7: After the command writes of ops 0 to 2, the block reads `req_addr` again and again. It reports `done` with `err`=0 only once `AGREE_READS` (default 4) successive reads agree in bit 6. That is never while the flash is still busy.
- R8: If polling has not settled after `TIMEOUT_CYC` cycles, the block ends the operation with `done` and `err` both 1.
- R9: Op code 3 (ID read) writes AAh@555h, 55h@2AAh and 90h@555h. It waits at least `ID_WAIT_CYC` cycles, reads `req_addr`, writes F0h at address 0, and waits at least `ID_WAIT_CYC` cycles. It then pulses `done` with the byte read on `rd_data`.
- R10: `req_ready` is low from acceptance until `done`, and requests made in that span are ignored. `done` lasts one cycle, and `err` is only ever high together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle if valid |
| req_op | input | 2 | 0 program, 1 sector erase, 2 full erase, 3 ID read |
| req_addr | input | AW | Target byte / sector / ID address |
| req_data | input | 8 | Byte to program |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with done |
| rd_data | output | 8 | ID byte, valid with done of op 3 |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 8 | Flash write data |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | 8 | Flash read data |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
Embedded assertions check on every cycle that the strobes are mutually exclusive, that the bus is held during a write pulse, that the bus is released during reads, and that the pulse rules on `done`, `err` and `req_ready` hold. Several behaviours can only be shown by the bench's scenarios against its behavioural flash model. These are the exact command byte order for each operation, the pulse and gap widths, the agreement on four reads across a finish that lands mid-poll, the timeout error against a flash that never settles, and the ID byte together with the wait windows around ID mode.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_IDRD = 2'd3
    } op_e;

    // One entry of the command table: fixed address/data unless the
    // request supplies them.
    typedef struct packed {
        logic [10:0] addr;
        logic [7:0]  data;
        logic        use_addr;
        logic        use_data;
        logic        last;
    } step_t;

    function automatic step_t cmd_step(op_e op, logic [2:0] idx, logic exit_ph);
        step_t s;
        s = '{addr: 11'h555, data: 8'hAA, use_addr: 1'b0, use_data: 1'b0, last: 1'b0};
        if (op == OP_IDRD && exit_ph) begin
            s.addr = 11'h000;
            s.data = 8'hF0;
            s.last = 1'b1;
        end else begin
            case (idx)
                3'd0: s.data = 8'hAA;
                3'd1: begin s.addr = 11'h2AA; s.data = 8'h55; end
                3'd2: begin
                    s.data = (op == OP_PROG) ? 8'hA0 : (op == OP_IDRD) ? 8'h90 : 8'h80;
                    s.last = (op == OP_IDRD);
                end
                3'd3: begin
                    s.data     = 8'hAA;
                    s.use_addr = (op == OP_PROG);
                    s.use_data = (op == OP_PROG);
                    s.last     = (op == OP_PROG);
                end
                3'd4: begin s.addr = 11'h2AA; s.data = 8'h55; end
                default: begin
                    s.use_addr = (op == OP_SECT);
                    s.data     = (op == OP_SECT) ? 8'h20 : 8'h10;
                    s.last     = 1'b1;
                end
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/pfs_bus_cycle.sv
module pfs_bus_cycle #(
    parameter int AW          = 19,
    parameter int WE_LOW_CYC  = 10,
    parameter int WE_HIGH_CYC = 8,
    parameter int RD_CYC      = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic          done,
    output logic [7:0]    rdata,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [7:0]    fl_dq_in,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);
    localparam int MAXC = (WE_LOW_CYC > RD_CYC) ?
                          ((WE_LOW_CYC > WE_HIGH_CYC) ? WE_LOW_CYC : WE_HIGH_CYC) :
                          ((RD_CYC > WE_HIGH_CYC) ? RD_CYC : WE_HIGH_CYC);
    localparam int CW = $clog2(MAXC + 1);

    typedef enum logic [1:0] {B_IDLE, B_SETUP, B_STROBE, B_HOLD} bph_e;

    typedef struct packed {
        bph_e          ph;
        logic          rd;
        logic [AW-1:0] addr;
        logic [7:0]    wd;
        logic [CW-1:0] cnt;
        logic [7:0]    rdat;
        logic          done;
    } bst_t;

    bst_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.ph)
            B_IDLE: if (start) begin
                st_d.ph   = B_SETUP;
                st_d.rd   = rd;
                st_d.addr = addr;
                st_d.wd   = wdata;
                st_d.cnt  = '0;
            end
            B_SETUP: begin
                st_d.ph  = B_STROBE;
                st_d.cnt = '0;
            end
            B_STROBE: begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.rd ? (st_q.cnt == CW'(RD_CYC - 1)) : (st_q.cnt == CW'(WE_LOW_CYC - 1))) begin
                    if (st_q.rd) st_d.rdat = fl_dq_in;
                    st_d.ph  = B_HOLD;
                    st_d.cnt = '0;
                end
            end
            default: begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == CW'(WE_HIGH_CYC - 1)) begin
                    st_d.ph   = B_IDLE;
                    st_d.done = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: B_IDLE, rd: 1'b0, addr: '0, wd: '0, cnt: '0, rdat: '0, done: 1'b0};
        else        st_q <= st_d;
    end

    assign done      = st_q.done;
    assign rdata     = st_q.rdat;
    assign fl_addr   = st_q.addr;
    assign fl_dq_out = st_q.wd;
    assign fl_ce_n   = (st_q.ph == B_IDLE);
    assign fl_we_n   = !(st_q.ph == B_STROBE && !st_q.rd);
    assign fl_oe_n   = !(st_q.ph == B_STROBE && st_q.rd);
    assign fl_dq_oe  = (st_q.ph != B_IDLE) && !st_q.rd;

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> (fl_oe_n && !fl_ce_n));
    // R5
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));
    // R6
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> (!fl_dq_oe && !fl_ce_n));

endmodule

// File: rtl/pfs_toggle_judge.sv
module pfs_toggle_judge #(
    parameter int AGREE_READS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic smp_valid,
    input  logic smp_bit,
    output logic settle
);
    localparam int RW = $clog2(AGREE_READS + 1);

    typedef struct packed {
        logic [RW-1:0] run;
        logic          prev;
    } jst_t;

    jst_t js_d, js_q;

    assign settle = smp_valid && (js_q.run != '0) && (smp_bit == js_q.prev) &&
                    (js_q.run >= RW'(AGREE_READS - 1));

    always_comb begin
        js_d = js_q;
        if (clr) begin
            js_d.run = '0;
        end else if (smp_valid) begin
            if (js_q.run == '0 || smp_bit != js_q.prev) js_d.run = RW'(1);
            else if (js_q.run != RW'(AGREE_READS))      js_d.run = js_q.run + 1'b1;
            js_d.prev = smp_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) js_q <= '{run: '0, prev: 1'b0};
        else        js_q <= js_d;
    end

endmodule

// File: rtl/pfs_flash_seq.sv
module pfs_flash_seq
    import pfs_pkg::*;
#(
    parameter int AW          = 19,
    parameter int WE_LOW_CYC  = 10,
    parameter int WE_HIGH_CYC = 8,
    parameter int RD_CYC      = 14,
    parameter int ID_WAIT_CYC = 38,
    parameter int AGREE_READS = 4,
    parameter int TIMEOUT_CYC = 25500000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    output logic          done,
    output logic          err,
    output logic [7:0]    rd_data,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [7:0]    fl_dq_in,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);
    localparam int WW = $clog2(ID_WAIT_CYC + 1);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    typedef enum logic [2:0] {S_IDLE, S_CMD, S_POLL, S_IDWAIT, S_IDREAD} sst_e;

    typedef struct packed {
        sst_e          state;
        op_e           op;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic [2:0]    step;
        logic          exit_ph;
        logic          issued;
        logic [WW-1:0] wcnt;
        logic [TW-1:0] tmo;
        logic [7:0]    rdat;
        logic          done;
        logic          err;
    } st_t;

    st_t st_d, st_q;

    logic          bus_start, bus_rd, bus_done, judge_clr, settle;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wd, bus_rdata;
    step_t         stp;

    assign stp = cmd_step(st_q.op, st_q.step, st_q.exit_ph);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        bus_start = 1'b0;
        bus_rd    = 1'b0;
        bus_addr  = st_q.addr;
        bus_wd    = st_q.data;
        judge_clr = 1'b0;
        case (st_q.state)
            S_IDLE: if (req_valid) begin
                st_d.state   = S_CMD;
                st_d.op      = op_e'(req_op);
                st_d.addr    = req_addr;
                st_d.data    = req_data;
                st_d.step    = '0;
                st_d.exit_ph = 1'b0;
                st_d.issued  = 1'b0;
                st_d.rdat    = '0;
                judge_clr    = 1'b1;
            end
            S_CMD: begin
                bus_addr = stp.use_addr ? st_q.addr : AW'(stp.addr);
                bus_wd   = stp.use_data ? st_q.data : stp.data;
                if (!st_q.issued) begin
                    bus_start   = 1'b1;
                    st_d.issued = 1'b1;
                end else if (bus_done) begin
                    st_d.issued = 1'b0;
                    if (!stp.last) begin
                        st_d.step = st_q.step + 1'b1;
                    end else if (st_q.op == OP_IDRD) begin
                        st_d.state = S_IDWAIT;
                        st_d.wcnt  = '0;
                    end else begin
                        st_d.state = S_POLL;
                        st_d.tmo   = '0;
                    end
                end
            end
            S_IDWAIT: begin
                st_d.wcnt = st_q.wcnt + 1'b1;
                if (st_q.wcnt == WW'(ID_WAIT_CYC - 1)) begin
                    if (st_q.exit_ph) begin
                        st_d.state = S_IDLE;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.state  = S_IDREAD;
                        st_d.issued = 1'b0;
                    end
                end
            end
            S_IDREAD: begin
                bus_rd = 1'b1;
                if (!st_q.issued) begin
                    bus_start   = 1'b1;
                    st_d.issued = 1'b1;
                end else if (bus_done) begin
                    st_d.rdat    = bus_rdata;
                    st_d.exit_ph = 1'b1;
                    st_d.step    = '0;
                    st_d.issued  = 1'b0;
                    st_d.state   = S_CMD;
                end
            end
            default: begin
                bus_rd = 1'b1;
                if (st_q.tmo != TW'(TIMEOUT_CYC)) st_d.tmo = st_q.tmo + 1'b1;
                if (!st_q.issued) begin
                    bus_start   = 1'b1;
                    st_d.issued = 1'b1;
                end else if (bus_done) begin
                    st_d.issued = 1'b0;
                    if (settle) begin
                        st_d.state = S_IDLE;
                        st_d.done  = 1'b1;
                    end else if (st_q.tmo == TW'(TIMEOUT_CYC)) begin
                        st_d.state = S_IDLE;
                        st_d.done  = 1'b1;
                        st_d.err   = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: S_IDLE, op: OP_PROG, addr: '0, data: '0, step: '0,
                              exit_ph: 1'b0, issued: 1'b0, wcnt: '0, tmo: '0,
                              rdat: '0, done: 1'b0, err: 1'b0};
        else        st_q <= st_d;
    end

    pfs_bus_cycle #(
        .AW(AW), .WE_LOW_CYC(WE_LOW_CYC), .WE_HIGH_CYC(WE_HIGH_CYC), .RD_CYC(RD_CYC)
    ) u_bus (
        .clk(clk), .rst_n(rst_n), .start(bus_start), .rd(bus_rd), .addr(bus_addr),
        .wdata(bus_wd), .done(bus_done), .rdata(bus_rdata), .fl_addr(fl_addr),
        .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    pfs_toggle_judge #(.AGREE_READS(AGREE_READS)) u_judge (
        .clk(clk), .rst_n(rst_n), .clr(judge_clr),
        .smp_valid(bus_done && st_q.state == S_POLL),
        .smp_bit(bus_rdata[6]), .settle(settle)
    );

    assign req_ready = (st_q.state == S_IDLE);
    assign done      = st_q.done;
    assign err       = st_q.err;
    assign rd_data   = st_q.rdat;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);
    // R5
    no_strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !done && $past(req_ready)) |-> fl_ce_n);

endmodule

// File: tb/pfs_flash_seq_test.sv
module pfs_flash_seq_test;
    localparam int AW = 19, WEL = 10, WEH = 8, RDC = 14, IDW = 38, TMO = 3000;
    localparam int PROG_T = 70, SECT_T = 300, CHIP_T = 600;
    localparam logic [7:0] MFR = 8'hC7, DEV = 8'h3E;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic req_ready, done, err, fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;
    logic [7:0] rd_data, fl_dq_out;
    logic [7:0] fl_dq_in = 8'hFF;
    logic [AW-1:0] fl_addr;

    always #2 clk = ~clk;

    pfs_flash_seq #(.AW(AW), .WE_LOW_CYC(WEL), .WE_HIGH_CYC(WEH), .RD_CYC(RDC),
        .ID_WAIT_CYC(IDW), .AGREE_READS(4), .TIMEOUT_CYC(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .done(done),
        .err(err), .rd_data(rd_data), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out),
        .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n),
        .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n));

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    string cur_tag = "R2";

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // behavioural flash model and per-cycle bus reference
    logic [AW+7:0] exp_q[$];
    logic [7:0] mem [int];
    int mstep = 0, busy_left = 0, reads_idle = 0;
    bit busy = 0, stuck = 0, tog = 0, id_mode = 0;
    bit prev_we = 1, prev_oe = 1, op_active = 0, ready_bad = 0, strobe_bad = 0;
    int we_low = 0, we_high = 1000, oe_low = 0, last_rise = 0;
    int cur_op = 0;

    function automatic logic [7:0] rd_mem(int a);
        return mem.exists(a) ? mem[a] : 8'hFF;
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (busy && !stuck) begin
                busy_left--;
                if (busy_left <= 0) begin busy = 0; reads_idle = 0; end
            end
            if (!fl_we_n && (!fl_oe_n || fl_ce_n)) strobe_bad = 1;
            if (op_active && req_ready && !done) ready_bad = 1;
            // write-enable edges
            if (!fl_we_n) begin
                if (prev_we) chk(we_high >= WEH, "R5", "we high gap", we_high, WEH);
                we_low++; we_high = 0;
            end else begin
                if (!prev_we) begin
                    logic [AW+7:0] e;
                    int a; logic [7:0] d;
                    chk(we_low == WEL, "R5", "we low width", we_low, WEL);
                    last_rise = cyc;
                    a = int'(fl_addr); d = fl_dq_out;
                    e = exp_q.size() ? exp_q.pop_front() : '1;
                    chk(e == {fl_addr, d}, cur_tag, "write addr/data", {fl_addr, d}, e);
                    if (!busy) begin
                        if (d == 8'hF0) begin id_mode = 0; mstep = 0; end
                        else case (mstep)
                            0: mstep = (d == 8'hAA && a[10:0] == 11'h555) ? 1 : 0;
                            1: mstep = (d == 8'h55 && a[10:0] == 11'h2AA) ? 2 : 0;
                            2: begin
                                mstep = (d == 8'hA0) ? 3 : (d == 8'h80) ? 4 : 0;
                                if (d == 8'h90) id_mode = 1;
                            end
                            3: begin mem[a] = d; busy = 1; busy_left = PROG_T; reads_idle = 0; mstep = 0; end
                            4: mstep = (d == 8'hAA) ? 5 : 0;
                            5: mstep = (d == 8'h55) ? 6 : 0;
                            default: begin
                                if (d == 8'h20) begin
                                    for (int k = 0; k < 128; k++) mem[(a & ~127) + k] = 8'hFF;
                                    busy = 1; busy_left = SECT_T;
                                end else if (d == 8'h10) begin
                                    mem.delete(); busy = 1; busy_left = CHIP_T;
                                end
                                reads_idle = 0; mstep = 0;
                            end
                        endcase
                    end
                end
                we_low = 0; we_high++;
            end
            // output-enable edges
            if (!fl_oe_n) begin
                if (prev_oe) begin
                    if (cur_op == 3) chk(cyc - last_rise >= IDW, "R9", "gap before ID read", cyc - last_rise, IDW);
                    if (busy) begin tog = ~tog; fl_dq_in <= {1'b0, tog, 6'b0}; end
                    else begin
                        reads_idle++;
                        fl_dq_in <= id_mode ? (fl_addr[0] ? DEV : MFR) : rd_mem(int'(fl_addr));
                    end
                end
                oe_low++;
            end else begin
                if (!prev_oe) chk(oe_low == RDC, "R6", "read strobe width", oe_low, RDC);
                oe_low = 0;
            end
            prev_we = fl_we_n; prev_oe = fl_oe_n;
        end
    end

    task automatic push_unlock();
        exp_q.push_back({AW'(11'h555), 8'hAA});
        exp_q.push_back({AW'(11'h2AA), 8'h55});
    endtask

    // issues one request, returns err/rd_data and the cycles it took
    task automatic run_op(int op, logic [AW-1:0] a, logic [7:0] d, int junk_cyc,
                          output bit e_out, output logic [7:0] r_out, output int took);
        int t0, lim;
        cur_op = op;
        cur_tag = (op == 0) ? "R2" : (op == 1) ? "R3" : (op == 2) ? "R4" : "R9";
        push_unlock();
        case (op)
            0: begin exp_q.push_back({AW'(11'h555), 8'hA0}); exp_q.push_back({a, d}); end
            1, 2: begin
                exp_q.push_back({AW'(11'h555), 8'h80}); push_unlock();
                exp_q.push_back(op == 1 ? {a, 8'h20} : {AW'(11'h555), 8'h10});
            end
            default: begin exp_q.push_back({AW'(11'h555), 8'h90}); exp_q.push_back({AW'(0), 8'hF0}); end
        endcase
        @(negedge clk);
        req_valid = 1; req_op = op[1:0]; req_addr = a; req_data = d;
        @(negedge clk);
        op_active = 1; t0 = cyc;
        if (junk_cyc > 0) begin
            req_op = 2'd2; req_addr = '0;
            repeat (junk_cyc) @(negedge clk);
        end
        req_valid = 0;
        lim = 0;
        while (!done && lim < 20000) begin @(negedge clk); #1; lim++; end
        took = cyc - t0;
        op_active = 0;
        e_out = err; r_out = rd_data;
        chk(done, "R10", "done seen", done, 1);
        @(negedge clk); #1;
        chk(!done, "R10", "done one cycle", done, 0);
        chk(exp_q.size() == 0, cur_tag, "writes left over", exp_q.size(), 0);
        exp_q.delete();
        chk(!ready_bad, "R10", "ready low while busy", ready_bad, 0);
        ready_bad = 0;
    endtask

    initial begin
        bit e; logic [7:0] r; int took;
        repeat (3) @(negedge clk);
        #1;
        chk(req_ready, "R1", "ready after reset", req_ready, 1);
        chk(fl_ce_n && fl_we_n && fl_oe_n, "R1", "strobes idle", {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
        chk(!done && !err, "R1", "done/err low", {done, err}, 0);
        rst_n = 1;

        // R2 program, with junk requests held while busy (R10)
        run_op(0, 19'h01234, 8'h3C, 30, e, r, took);
        chk(!e, "R2", "program err", e, 0);
        chk(rd_mem(32'h1234) == 8'h3C, "R2", "byte stored", rd_mem(32'h1234), 8'h3C);
        chk(!busy && reads_idle >= 3, "R7", "settled after program", reads_idle, 3);

        run_op(0, 19'h01290, 8'h5A, 0, e, r, took);
        chk(!e && !busy && reads_idle >= 3, "R7", "second program settle", reads_idle, 3);

        // R3 sector erase covers 0x1200..0x127F
        run_op(1, 19'h01200, 8'h00, 0, e, r, took);
        chk(!e && !busy, "R3", "sector erase finished", busy, 0);
        chk(rd_mem(32'h1234) == 8'hFF, "R3", "sector cleared", rd_mem(32'h1234), 8'hFF);
        chk(rd_mem(32'h1290) == 8'h5A, "R3", "next sector kept", rd_mem(32'h1290), 8'h5A);
        chk(reads_idle >= 3, "R7", "settled after sector erase", reads_idle, 3);

        // R4 full erase
        run_op(2, 19'h00000, 8'h00, 0, e, r, took);
        chk(!e && !busy, "R4", "full erase finished", busy, 0);
        chk(rd_mem(32'h1290) == 8'hFF, "R4", "array cleared", rd_mem(32'h1290), 8'hFF);

        // R9 ID reads
        run_op(3, 19'h00000, 8'h00, 0, e, r, took);
        chk(r == MFR, "R9", "ID byte 0", r, MFR);
        chk(cyc - last_rise >= IDW, "R9", "wait after exit", cyc - last_rise, IDW);
        chk(!id_mode, "R9", "ID mode left", id_mode, 0);
        run_op(3, 19'h00001, 8'h00, 0, e, r, took);
        chk(r == DEV, "R9", "ID byte 1", r, DEV);
        chk(!e, "R10", "no err on ID read", e, 0);

        // R8 timeout: flash never settles
        stuck = 1;
        run_op(1, 19'h00400, 8'h00, 0, e, r, took);
        chk(e, "R8", "timeout err", e, 1);
        chk(took >= TMO, "R8", "timeout span", took, TMO);
        stuck = 0; busy = 0;

        run_op(0, 19'h00410, 8'hA5, 0, e, r, took);
        chk(!e && rd_mem(32'h410) == 8'hA5, "R2", "program after timeout", rd_mem(32'h410), 8'hA5);

        chk(!strobe_bad, "R5", "we only with ce low and oe high", strobe_bad, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule